// File: doc/BRIEF.md
# Gate Driver Fault Latch Supervisor

This block is the fault memory of a two-channel gate driver for a half bridge. It watches a desaturation flag from each power switch and a supply-undervoltage comparator flag. Once a fault is accepted, it stores it and gates off every turn-on command to both switches. It drives a fault status line whose active level is chosen by a strap. It also raises a soft turn-off request for each channel whose desaturation flag tripped. The request tells the output stage to discharge that gate slowly.

The control side clears the memory without a dedicated reset pin. It pulls both gate commands low and keeps them low for longer than a minimum time. A short dip of the supply flag is filtered out, because undervoltage is accepted only after it persists. Both time windows are given in clock cycles by parameters. The defaults assume a 10 MHz clock: 5000 cycles for the undervoltage window and 50 cycles for the clearing window.

Top module: `drv_fault_latch`

## Requirements
- R1: The fault memory sets on the clock edge after either desaturation flag is sampled high, or after undervoltage qualifies. No other input sets it. An asynchronous active-low reset clears the memory, both counters and both soft turn-off requests.
- R2: Undervoltage qualifies only when `uv_flag` has been sampled high on more than `UV_HOLD` consecutive edges. If the flag is high on exactly `UV_HOLD` edges and then drops, nothing is latched. A single low sample restarts the count.
- R3: While the memory is set, `gate_a` and `gate_b` are 0. While it is clear, `gate_a` follows `cmd_a` and `gate_b` follows `cmd_b` in the same cycle.
- R4: The memory clears only on the edge at which both commands have been sampled low on more than `CLR_HOLD` consecutive edges, that is on edge `CLR_HOLD`+1. Any edge with a command high restarts this count.
- R5: The fault status is asserted only when the memory is set and at least one command is high. When both commands are low, or when no fault is stored, the status is deasserted.
- R6: With `pol_low` = 0, `fault_o` = 1 means asserted. With `pol_low` = 1, every level of `fault_o` is complemented.
- R7: `soft_off_a` (or `soft_off_b`) goes high on the edge after `desat_a` (or `desat_b`) is sampled high. It stays high until the memory clears. Undervoltage and the other channel's flag never raise it.
- R8: Clearing takes priority over a cause present on the same edge. If the cause is still present afterwards, the memory sets again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 1 | Turn-on command, switch A (1 = on) |
| cmd_b | input | 1 | Turn-on command, switch B (1 = on) |
| desat_a | input | 1 | Desaturation (short-circuit) flag, switch A |
| desat_b | input | 1 | Desaturation (short-circuit) flag, switch B |
| uv_flag | input | 1 | Supply-below-threshold comparator flag |
| pol_low | input | 1 | Status polarity strap (1 = active-low) |
| gate_a | output | 1 | Gated turn-on for switch A |
| gate_b | output | 1 | Gated turn-on for switch B |
| fault_o | output | 1 | Fault status at the strapped polarity |
| soft_off_a | output | 1 | Slow turn-off request, switch A |
| soft_off_b | output | 1 | Slow turn-off request, switch B |

## Verification
The bench toggles gate commands with no fault present, to confirm that the commands pass through unchanged. It then applies a short-circuit on one channel, on the other channel, and on both, which separates the per-channel soft turn-off requests from the shared blocking. Undervoltage pulses lasting exactly the window, one cycle longer, and with a one-cycle dropout test where the persistence filter draws its line. Clearing attempts with a one-cycle command glitch, attempts completed under normal conditions, and attempts completed while a fault is still present check the reset width and the re-latch rule, under both strap settings.

// File: rtl/drv_fault_latch.sv
module drv_fault_latch #(
  parameter int UV_HOLD  = 5000,
  parameter int CLR_HOLD = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_a,
  input  logic cmd_b,
  input  logic desat_a,
  input  logic desat_b,
  input  logic uv_flag,
  input  logic pol_low,
  output logic gate_a,
  output logic gate_b,
  output logic fault_o,
  output logic soft_off_a,
  output logic soft_off_b
);
  localparam int UW = $clog2(UV_HOLD + 1);
  localparam int CW = $clog2(CLR_HOLD + 1);
  localparam logic [UW-1:0] UV_TOP  = UW'(UV_HOLD);
  localparam logic [CW-1:0] CLR_TOP = CW'(CLR_HOLD);

  logic [UW-1:0] uv_cnt;
  logic [CW-1:0] idle_cnt;
  logic          trip_q;
  logic          soft_a_q, soft_b_q;

  wire idle    = ~cmd_a & ~cmd_b;
  wire uv_ok   = uv_flag & (uv_cnt == UV_TOP);
  wire idle_ok = idle & (idle_cnt == CLR_TOP);
  wire cause   = desat_a | desat_b | uv_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            uv_cnt <= '0;
    else if (!uv_flag)     uv_cnt <= '0;
    else if (uv_cnt != UV_TOP) uv_cnt <= uv_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idle_cnt <= '0;
    else if (!idle)             idle_cnt <= '0;
    else if (idle_cnt != CLR_TOP) idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q   <= 1'b0;
      soft_a_q <= 1'b0;
      soft_b_q <= 1'b0;
    end else if (idle_ok) begin
      trip_q   <= 1'b0;
      soft_a_q <= 1'b0;
      soft_b_q <= 1'b0;
    end else begin
      if (cause) trip_q <= 1'b1;
      soft_a_q <= soft_a_q | desat_a;
      soft_b_q <= soft_b_q | desat_b;
    end
  end

  assign gate_a     = cmd_a & ~trip_q;
  assign gate_b     = cmd_b & ~trip_q;
  assign fault_o    = (trip_q & ~idle) ^ pol_low;
  assign soft_off_a = soft_a_q;
  assign soft_off_b = soft_b_q;

  AST_DESAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(desat_a | desat_b) && $past(!idle_ok) |-> !gate_a && !gate_b); // R3
  AST_SOFT_FROM_DESAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(soft_off_a) |-> $past(desat_a)); // R7
  AST_CLEAR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(trip_q) |-> $past(!cmd_a && !cmd_b)); // R4
  AST_NO_EARLY_UV: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_q && !desat_a && !desat_b && (uv_cnt != UV_TOP) |=> !trip_q); // R2
  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_a && !cmd_b |-> fault_o == pol_low); // R5
endmodule

// File: tb/drv_fault_latch_bench.sv
module drv_fault_latch_bench;
  localparam int PERIOD = 10;
  localparam int UVH = 40;
  localparam int CLH = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_a = 0, cmd_b = 0, desat_a = 0, desat_b = 0, uv_flag = 0, pol_low = 0;
  logic gate_a, gate_b, fault_o, soft_off_a, soft_off_b;
  int vecs = 0, bad = 0;
  bit done = 0;

  drv_fault_latch #(.UV_HOLD(UVH), .CLR_HOLD(CLH)) u_drv_fault_latch (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .desat_a(desat_a), .desat_b(desat_b), .uv_flag(uv_flag), .pol_low(pol_low),
    .gate_a(gate_a), .gate_b(gate_b), .fault_o(fault_o),
    .soft_off_a(soft_off_a), .soft_off_b(soft_off_b));

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference: run lengths as plain integers
  int  uv_run = 0, idle_run = 0;
  bit  m_trip = 0, m_sa = 0, m_sb = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      bit clr, uvq;
      uvq = uv_flag && uv_run >= UVH;
      clr = !cmd_a && !cmd_b && idle_run >= CLH;
      if (clr) begin m_trip = 0; m_sa = 0; m_sb = 0; end
      else begin
        if (desat_a || desat_b || uvq) m_trip = 1;
        if (desat_a) m_sa = 1;
        if (desat_b) m_sb = 1;
      end
      uv_run   = uv_flag ? uv_run + 1 : 0;
      idle_run = (!cmd_a && !cmd_b) ? idle_run + 1 : 0;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic st;
    st = (m_trip && (cmd_a || cmd_b)) ^ pol_low;
    chk("R3 gate_a", gate_a, cmd_a && !m_trip);
    chk("R3 gate_b", gate_b, cmd_b && !m_trip);
    chk("R5/R6 fault_o", fault_o, st);
    chk("R7 soft_off_a", soft_off_a, m_sa);
    chk("R7 soft_off_b", soft_off_b, m_sb);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      compare();
    end
  endtask

  task automatic settle_inputs();
    #1; compare();
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      bad++; vecs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R1 reset gate_a", gate_a, 1'b0);
    chk("R1 reset fault_o", fault_o, 1'b0);
    chk("R1 reset soft", soft_off_a | soft_off_b, 1'b0);
    @(negedge clk); rst_n = 1;
    tick(2);
    // R3 passthrough, several command patterns
    for (int p = 0; p < 8; p++) begin
      cmd_a = p[0]; cmd_b = p[1]; tick(1);
    end
    // R1 R7 desat on A
    cmd_a = 1; cmd_b = 0; desat_a = 1; tick(1);
    chk("R1 trip after desat_a", gate_a, 1'b0);
    chk("R7 soft_a set", soft_off_a, 1'b1);
    chk("R7 soft_b untouched", soft_off_b, 1'b0);
    desat_a = 0; cmd_b = 1; tick(3);
    chk("R3 blocked b", gate_b, 1'b0);
    chk("R5 status active", fault_o, 1'b1);
    // R4 clear attempt with a glitch
    cmd_a = 0; cmd_b = 0; tick(1);
    chk("R5 status idle", fault_o, 1'b0);
    tick(CLH - 3); cmd_b = 1; tick(1); cmd_b = 0; tick(CLH);
    cmd_a = 1; settle_inputs();
    chk("R4 glitch restarts window", gate_a, 1'b0);
    cmd_a = 0; tick(CLH + 1);
    cmd_a = 1; settle_inputs();
    chk("R4 cleared after window", gate_a, 1'b1);
    chk("R7 soft cleared", soft_off_a, 1'b0);
    tick(2);
    // R6 polarity, desat on B, both
    pol_low = 1; tick(1);
    chk("R6 idle inactive-high", fault_o, 1'b1);
    desat_b = 1; tick(1); desat_b = 0;
    chk("R6 active low", fault_o, 1'b0);
    chk("R7 soft_b set", soft_off_b, 1'b1);
    chk("R7 soft_a stays low", soft_off_a, 1'b0);
    desat_a = 1; tick(1); desat_a = 0; tick(1);
    cmd_a = 0; cmd_b = 0; tick(CLH + 2);
    pol_low = 0; cmd_b = 1; tick(2);
    // R2 undervoltage exactly UVH edges: no trip
    uv_flag = 1; tick(UVH); uv_flag = 0; tick(2);
    chk("R2 exact window no trip", gate_b, 1'b1);
    // R2 dropout restarts
    uv_flag = 1; tick(UVH - 5); uv_flag = 0; tick(1); uv_flag = 1; tick(UVH - 5);
    chk("R2 dropout restarts", gate_b, 1'b1);
    uv_flag = 0; tick(1);
    // R1 sustained undervoltage trips, no soft request
    uv_flag = 1; tick(UVH + 1);
    chk("R1 uv trips", gate_b, 1'b0);
    chk("R7 uv no soft", soft_off_b, 1'b0);
    // R8 clear while undervoltage persists
    cmd_a = 0; cmd_b = 0; tick(CLH + 1);
    cmd_a = 1; settle_inputs();
    chk("R8 momentary clear", gate_a, 1'b1);
    tick(1);
    chk("R8 relatch next edge", gate_a, 1'b0);
    uv_flag = 0; cmd_a = 0; tick(CLH + 2);
    cmd_a = 1; cmd_b = 1; tick(3);
    chk("R3 normal again", gate_a & gate_b, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule